// File: doc/BRIEF.md
# LIN Bus Remote Wake-up Qualifier

This block decides whether activity on a LIN bus, seen while the local transceiver rests in sleep or silent mode, is a genuine remote wake-up request. It watches three digitised comparator levels (bus below the pre-wake-low level, bus below the dominant level, bus above the pre-wake-high level), the current low-power mode and the transmit-data pin level. It powers the bus receiver only while there is something to qualify, and it raises a one-cycle wake strobe when a valid request has been seen.

A request is valid when the bus goes dominant, stays dominant for at least the filter time and is then released. A monitoring window starts when the receiver is powered. If that window runs out while the bus hangs between the dominant and pre-wake-low levels (a floating bus), the receiver is switched off. The block then ignores the bus until the bus has sat above the pre-wake-high level for a re-arm time. If the window runs out while the bus is still dominant (a bus shorted to ground), the receiver is also switched off, and the next release of the bus counts as a wake on its own. All timing is given in clock cycles through parameters. A mode controller uses the strobe to leave the low-power mode, and it uses the expiry indication to tell a parked receiver from an idle one.

Top module: `lin_wake_detector`

## Requirements
- R1: When `mode_i` is neither 2'b01 (sleep) nor 2'b10 (silent), all three outputs are low from the next clock edge and every internal timer is cleared. This holds whatever the bus inputs do. At reset all outputs are low.
- R2: In a low-power mode with the receiver idle, a sampled `bus_below_prewake_i` of 1 sets `rx_en_o` high after that clock edge.
- R3: While `rx_en_o` is high, `bus_below_dom_i` may be sampled high on at least FILT_CYC consecutive edges and then low. `wake_o` then goes high after the edge that samples it low, and `rx_en_o` falls at the same edge.
- R4: A dominant run shorter than FILT_CYC sampled edges gives no wake. If the bus is then sampled neither dominant nor below the pre-wake-low level, `rx_en_o` falls.
- R5: `wake_o` is never high for two consecutive cycles.
- R6: `rx_en_o` may stay high for MON_CYC cycles without a qualified wake, with the bus not dominant on the last of those edges. `rx_en_o` then falls and `mon_expired_o` rises at that edge.
- R7: After the expiry of R6, the bus inputs below the pre-wake-low and dominant levels have no effect: `rx_en_o` and `wake_o` stay low. This lasts until `bus_above_high_i` has been sampled high on REARM_CYC consecutive edges. `mon_expired_o` then falls after that last edge.
- R8: If the window of R6 expires with the bus sampled dominant, `rx_en_o` falls and `mon_expired_o` rises. The next edge that samples `bus_below_dom_i` low after a high raises `wake_o` for one cycle, whatever the pulse width, and clears `mon_expired_o`.
- R9: In silent mode (2'b10), a release sampled with `txd_i` low gives no wake, and the block returns to idle with all outputs low. In sleep mode (2'b01) the level of `txd_i` does not matter.
- R10: `rx_en_o` and `mon_expired_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 2'b01 sleep, 2'b10 silent, other codes awake |
| txd_i | input | 1 | Level of the transmit-data pin |
| bus_below_prewake_i | input | 1 | Bus below the pre-wake-low level |
| bus_below_dom_i | input | 1 | Bus below the dominant level |
| bus_above_high_i | input | 1 | Bus above the pre-wake-high level |
| rx_en_o | output | 1 | Bus receiver power enable |
| wake_o | output | 1 | One-cycle remote wake strobe |
| mon_expired_o | output | 1 | Monitoring window ran out; receiver parked |

## Verification
A wrong state or counter shows at the ports within one clock edge of the event it mishandles. A monitor counter that is off by one moves the edge where `rx_en_o` falls and `mon_expired_o` rises. A dominant-width counter with the wrong limit turns a FILT_CYC-1 pulse into a wake, or a FILT_CYC pulse into silence, at the release edge. A lockout that leaves too early shows as `rx_en_o` rising while the bus is still floating, and a lost short-circuit state shows as a missing strobe at the release edge. The bench compares all three outputs after every edge, so each of these errors is reported in the cycle where it first differs.

// File: rtl/lin_wake_pkg.sv
package lin_wake_pkg;

  localparam logic [1:0] MODE_SLEEP  = 2'b01;
  localparam logic [1:0] MODE_SILENT = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WATCH = 2'd1,
    ST_FLOAT = 2'd2,
    ST_SHORT = 2'd3
  } wake_state_e;

  function automatic logic mode_asleep(input logic [1:0] m);
    return (m == MODE_SLEEP) || (m == MODE_SILENT);
  endfunction

  // Silent mode honours a wake only with the transmit pin high.
  function automatic logic wake_allowed(input logic [1:0] m, input logic txd);
    return (m == MODE_SLEEP) || txd;
  endfunction

endpackage

// File: rtl/lin_wake_timer.sv
module lin_wake_timer #(
  parameter int LIMIT = 16,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic         hit,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  assign hit = inc && (count == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count <= '0;
    else if (clr || hit) count <= '0;
    else if (inc)        count <= count + 1'b1;
  end

  // R6: the counter wraps at its limit and never runs past it.
  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LAST);

endmodule

// File: rtl/lin_wake_pulse.sv
module lin_wake_pulse #(
  parameter int FILT_CYC = 90
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic dom_i,
  output logic bus_release,
  output logic long_pulse
);

  localparam int W = $clog2(FILT_CYC + 1);
  localparam logic [W-1:0] FILT_W = W'(FILT_CYC);

  logic         dom_q;
  logic [W-1:0] width;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dom_q <= 1'b0;
      width <= '0;
    end else if (!enable) begin
      dom_q <= 1'b0;
      width <= '0;
    end else begin
      dom_q <= dom_i;
      if (!dom_i)               width <= '0;
      else if (width != FILT_W) width <= width + 1'b1;
    end
  end

  assign bus_release = enable && dom_q && !dom_i;
  assign long_pulse  = (width >= FILT_W);

  // R3: the width count saturates at the filter length.
  assert_width_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    width <= FILT_W);

  // R4: a release always restarts the width count.
  assert_release_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_release && enable) |=> (width == '0));

endmodule

// File: rtl/lin_wake_fsm.sv
module lin_wake_fsm
  import lin_wake_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        asleep,
  input  logic        permit,
  input  logic        bus_lo,
  input  logic        bus_dom,
  input  logic        bus_release,
  input  logic        long_pulse,
  input  logic        mon_hit,
  input  logic        rearm_hit,
  output wake_state_e state_o,
  output logic        rx_en_o,
  output logic        wake_o,
  output logic        mon_expired_o
);

  wake_state_e state_q, state_d;
  logic        wake_d, wake_q;

  always_comb begin
    state_d = state_q;
    wake_d  = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (bus_lo) state_d = ST_WATCH;
      ST_WATCH: begin
        if (bus_release && long_pulse) begin
          wake_d  = permit;
          state_d = ST_IDLE;
        end else if (mon_hit) begin
          state_d = bus_dom ? ST_SHORT : ST_FLOAT;
        end else if (!bus_lo && !bus_dom) begin
          state_d = ST_IDLE;
        end
      end
      ST_FLOAT: if (rearm_hit) state_d = ST_IDLE;
      ST_SHORT: begin
        if (bus_release) begin
          wake_d  = permit;
          state_d = ST_IDLE;
        end
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wake_q  <= 1'b0;
    end else if (!asleep) begin
      state_q <= ST_IDLE;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= wake_d;
    end
  end

  assign state_o       = state_q;
  assign rx_en_o       = (state_q == ST_WATCH);
  assign mon_expired_o = (state_q == ST_FLOAT) || (state_q == ST_SHORT);
  assign wake_o        = wake_q;

  assert_awake_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !asleep |=> (!rx_en_o && !wake_o && !mon_expired_o));

  assert_wake_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);

  assert_wake_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(rx_en_o || mon_expired_o));

  assert_float_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FLOAT) |=> (!rx_en_o && !wake_o));

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_en_o && mon_expired_o));

endmodule

// File: rtl/lin_wake_detector.sv
module lin_wake_detector
  import lin_wake_pkg::*;
#(
  parameter int FILT_CYC  = 90,
  parameter int MON_CYC   = 10000,
  parameter int REARM_CYC = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       txd_i,
  input  logic       bus_below_prewake_i,
  input  logic       bus_below_dom_i,
  input  logic       bus_above_high_i,
  output logic       rx_en_o,
  output logic       wake_o,
  output logic       mon_expired_o
);

  localparam int MON_W   = $clog2(MON_CYC + 1);
  localparam int REARM_W = $clog2(REARM_CYC + 1);

  logic              asleep, permit;
  logic              bus_release, long_pulse;
  logic              mon_inc, mon_clr, mon_hit;
  logic              rearm_inc, rearm_clr, rearm_hit;
  logic [MON_W-1:0]  mon_count;
  logic [REARM_W-1:0] rearm_count;
  wake_state_e       state;

  assign asleep = mode_asleep(mode_i);
  assign permit = wake_allowed(mode_i, txd_i);

  lin_wake_pulse #(.FILT_CYC(FILT_CYC)) i_pulse (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (asleep),
    .dom_i       (bus_below_dom_i),
    .bus_release (bus_release),
    .long_pulse  (long_pulse)
  );

  assign mon_inc = asleep && (state == ST_WATCH);
  assign mon_clr = !mon_inc;

  lin_wake_timer #(.LIMIT(MON_CYC)) i_mon_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (mon_clr),
    .inc   (mon_inc),
    .hit   (mon_hit),
    .count (mon_count)
  );

  assign rearm_inc = asleep && (state == ST_FLOAT) && bus_above_high_i;
  assign rearm_clr = !rearm_inc;

  lin_wake_timer #(.LIMIT(REARM_CYC)) i_rearm_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (rearm_clr),
    .inc   (rearm_inc),
    .hit   (rearm_hit),
    .count (rearm_count)
  );

  lin_wake_fsm i_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .asleep        (asleep),
    .permit        (permit),
    .bus_lo        (bus_below_prewake_i),
    .bus_dom       (bus_below_dom_i),
    .bus_release   (bus_release),
    .long_pulse    (long_pulse),
    .mon_hit       (mon_hit),
    .rearm_hit     (rearm_hit),
    .state_o       (state),
    .rx_en_o       (rx_en_o),
    .wake_o        (wake_o),
    .mon_expired_o (mon_expired_o)
  );

  // R6: the window runs only while the receiver is powered.
  assert_mon_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_o |=> (mon_count == '0) || rx_en_o);

  // R7: re-arm progress exists only in the floating lockout.
  assert_rearm_scope_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm_count != '0) |-> $past(state == ST_FLOAT));

  // R9: silent mode with transmit low never yields a strobe.
  assert_silent_txd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_SILENT && !txd_i) |=> !wake_o);

endmodule

// File: tb/test_lin_wake_detector.sv
module test_lin_wake_detector;

  localparam int FILT  = 6;
  localparam int MON   = 40;
  localparam int REARM = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       txd = 1'b1;
  logic       lo = 1'b0, dom = 1'b0, hi = 1'b1;
  logic       rx_en, wake, mexp;

  always #4 clk = ~clk;

  lin_wake_detector #(.FILT_CYC(FILT), .MON_CYC(MON), .REARM_CYC(REARM)) i_lin_wake_detector (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .txd_i(txd),
    .bus_below_prewake_i(lo), .bus_below_dom_i(dom), .bus_above_high_i(hi),
    .rx_en_o(rx_en), .wake_o(wake), .mon_expired_o(mexp));

  int    n_checks = 0, n_fail = 0, cyc = 0;
  bit    finished = 0;
  string req = "R1";

  // Reference: phase 0 resting, 1 listening, 2 parked floating, 3 parked shorted.
  int phase = 0, win = 0, rearm = 0, run_len = 0;
  bit last_dom = 0, exp_wake = 0;

  task automatic model_edge();
    bit low_power, released, long_run, allow;
    int old_phase;
    low_power = (mode == 2'b01) || (mode == 2'b10);
    if (!low_power) begin
      phase = 0; win = 0; rearm = 0; run_len = 0; last_dom = 0; exp_wake = 0;
      return;
    end
    released  = last_dom && !dom;
    long_run  = run_len >= FILT;
    allow     = (mode == 2'b01) || txd;
    old_phase = phase;
    exp_wake  = 0;
    if (old_phase == 0) begin
      if (lo) phase = 1;
    end else if (old_phase == 1) begin
      if (released && long_run) begin exp_wake = allow; phase = 0; end
      else if (win == MON - 1) phase = dom ? 3 : 2;
      else if (!lo && !dom) phase = 0;
    end else if (old_phase == 2) begin
      if (hi && rearm == REARM - 1) phase = 0;
    end else begin
      if (released) begin exp_wake = allow; phase = 0; end
    end
    win   = (old_phase == 1 && win != MON - 1) ? win + 1 : 0;
    rearm = (old_phase == 2 && hi && rearm != REARM - 1) ? rearm + 1 : 0;
    run_len  = dom ? ((run_len < FILT) ? run_len + 1 : FILT) : 0;
    last_dom = dom;
  endtask

  task automatic compare();
    bit e_rx, e_mx;
    e_rx = (phase == 1);
    e_mx = (phase == 2) || (phase == 3);
    n_checks++;
    if (rx_en !== e_rx || wake !== exp_wake || mexp !== e_mx) begin
      n_fail++;
      $display("FAIL %s cycle %0d: rx_en=%b/%b wake=%b/%b mon_expired=%b/%b (actual/expected)",
               req, cyc, rx_en, e_rx, wake, exp_wake, mexp, e_mx);
    end
    n_checks++;  // R10 exclusivity
    if (rx_en === 1'b1 && mexp === 1'b1) begin
      n_fail++;
      $display("FAIL R10 cycle %0d: rx_en=%b mon_expired=%b expected not both high", cyc, rx_en, mexp);
    end
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      cyc++;
      model_edge();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic bus(logic l, logic d, logic h);
    lo = l; dom = d; hi = h;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    req = "R1";
    compare();           // reset state
    rst_n = 1'b1;

    // R1: awake mode ignores the bus
    mode = 2'b00; bus(1, 1, 0); step(5);
    bus(0, 0, 1); step(2);

    // R2 R3 R5: qualified wake in sleep mode
    req = "R2"; mode = 2'b01; step(3);
    bus(1, 0, 0); step(2);
    req = "R3"; bus(1, 1, 0); step(FILT + 2);
    req = "R5"; bus(0, 0, 1); step(3);

    // R3 boundary: exactly FILT dominant edges
    req = "R3"; bus(1, 1, 0); step(FILT); bus(0, 0, 1); step(3);

    // R4: too-short pulses
    req = "R4"; bus(1, 1, 0); step(FILT - 1); bus(0, 0, 1); step(3);
    bus(1, 1, 0); step(2); bus(1, 0, 0); step(3); bus(0, 0, 1); step(2);

    // R6 R7: floating bus, lockout and re-arm
    req = "R6"; bus(1, 0, 0); step(MON + 3);
    req = "R7"; bus(1, 1, 0); step(FILT + 2); bus(1, 0, 0); step(2);
    bus(0, 0, 1); step(REARM - 1);
    bus(1, 0, 0); step(1);
    bus(0, 0, 1); step(REARM + 2);
    bus(1, 0, 0); step(2); bus(0, 0, 1); step(2);

    // R8: shorted bus, release wakes directly
    req = "R8"; bus(1, 1, 0); step(MON + 5);
    bus(0, 0, 1); step(3);

    // R9: silent mode gated by transmit level
    req = "R9"; mode = 2'b10; txd = 1'b0; step(2);
    bus(1, 1, 0); step(FILT + 2); bus(0, 0, 1); step(3);
    txd = 1'b1; bus(1, 1, 0); step(FILT + 2); bus(0, 0, 1); step(3);
    mode = 2'b01; txd = 1'b0; bus(1, 1, 0); step(FILT + 2); bus(0, 0, 1); step(3);
    mode = 2'b10; bus(1, 1, 0); step(MON + 2); bus(0, 0, 1); step(3);

    // R1: leaving low-power mode mid-qualification clears everything
    req = "R1"; mode = 2'b01; txd = 1'b1; bus(1, 1, 0); step(4);
    mode = 2'b11; step(3);
    mode = 2'b01; bus(0, 0, 1); step(3);

    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual hang expected completion");
    summary();
  end

endmodule